// File: doc/BRIEF.md
# Memory Bandwidth Accounting Unit

The block counts memory-traffic events over a sampling window of programmable length and turns the counts into byte totals. It produces one total for the whole chip and one total for each core. The chip-level inputs are single-cycle pulses from the memory controller, one for each dispatched read, write and prefetch. Each core supplies five event pulses:

- demand loads whose data came from beyond the outer cache;
- outer-cache misses;
- outer-cache demand-load misses;
- castouts that went to memory;
- prefetches that missed the outer cache.

A plain sum of the counters would give the wrong result. Prefetch dispatches are also counted as reads, so they are removed from the read count. The per-core outer-cache events are generated in a clock domain that runs at twice the rate of the traffic they describe, so their totals are halved. Each chip-level transfer counts as 1024 bytes and each core-level transfer as 128 bytes.

At the end of every window the results are held in output registers until the next window ends. A one-cycle done strobe marks each new result, and all counters restart from zero. Converting a byte total into a rate is left to the consumer.

Top module: `mem_bw_acct`

## Requirements
- R1: While reset is asserted and until the first window has ended, `chipBytes`, every `coreBytes` field and `done` are zero.
- R2: With `intervalLen` = L (a value of 0 acts as 1), a window lasts exactly L clock cycles starting at the first edge after reset. Every event pulse sampled in those L cycles, including the last one, counts toward that window. `done` is high for exactly one cycle right after the last edge of each window.
- R3: Each event counter is CNT_W bits wide and saturates at 2^CNT_W−1 instead of wrapping. Saturated totals are used as they stand in the byte formulas.
- R4: `chipBytes` = 1024 × (reads + writes + prefetches). Here reads = read dispatches − prefetch dispatches, writes = write dispatches, and prefetches = prefetch dispatches.
- R5: For core i, `coreBytes[i*CORE_W +: CORE_W]` = 128 × (D + ⌊(M−LM)/2⌋ + ⌊C/2⌋ + ⌊P/2⌋). D, M, LM, C and P are that core's window totals of demand-miss data, outer misses, outer demand-load misses, castouts and prefetch misses. Each halving applies to the window total and rounds down; it is not applied per event.
- R6: The outputs keep their values between window ends. Events from an earlier window never appear in a later result.
- R7: A difference that would be negative is taken as zero. This applies to read − prefetch dispatches and to outer misses − outer demand-load misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intervalLen | input | LEN_W | Window length in cycles (0 acts as 1) |
| rdDispEvt | input | 1 | Controller read dispatch pulse |
| wrDispEvt | input | 1 | Controller write dispatch pulse |
| pfDispEvt | input | 1 | Controller prefetch dispatch pulse |
| coreDemandMissEvt | input | NUM_CORES | Per-core demand-load data from beyond the outer cache |
| coreOuterMissEvt | input | NUM_CORES | Per-core outer-cache miss |
| coreOuterLdMissEvt | input | NUM_CORES | Per-core outer-cache demand-load miss |
| coreCastoutEvt | input | NUM_CORES | Per-core castout to memory |
| corePfMissEvt | input | NUM_CORES | Per-core prefetch missing the outer cache |
| chipBytes | output | CNT_W+12 | Latched chip byte total |
| coreBytes | output | NUM_CORES*(CNT_W+9) | Latched per-core byte totals, core 0 in the low field |
| done | output | 1 | One-cycle strobe marking new results |

## Verification
Every cycle, the assertions check the following:
- `done` follows the window-end strobe by one cycle and is otherwise low.
- The latched totals change only at a window end.
- The read-dispatch counter clears to zero after each window end.
- The read-dispatch counter never wraps once it is saturated.

The arithmetic can only be shown by the bench's scenarios. These cover the subtraction and its clamp, the rounding down of halved totals, inclusion of the last cycle's events, and saturated counts feeding the formulas.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic sampleEnd;   // latch results this cycle
    logic clearAcc;    // restart all counters at this edge
  } mbw_strb_t;
endpackage

// File: rtl/mbw_sat_acc.sv
module mbw_sat_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  // total including this cycle's event, held at the ceiling
  always_comb begin
    if (cnt == MAXV) nxt = cnt;
    else             nxt = cnt + {{(W-1){1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (!rstN)      cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= nxt;
  end
endmodule

// File: rtl/mbw_ctrl.sv
module mbw_ctrl
  import mbw_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] intervalLen,
  output mbw_strb_t        strb,
  output logic             done
);
  logic [LEN_W-1:0] cycCnt;
  logic [LEN_W-1:0] lastIdx;
  logic             endNow;

  assign lastIdx = (intervalLen == '0) ? '0 : intervalLen - 1'b1;
  assign endNow  = (cycCnt >= lastIdx);

  always_comb begin
    strb.sampleEnd = endNow;
    strb.clearAcc  = endNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
      done   <= 1'b0;
    end else begin
      cycCnt <= endNow ? '0 : cycCnt + 1'b1;
      done   <= endNow;
    end
  end
endmodule

// File: rtl/mbw_datapath.sv
module mbw_datapath
  import mbw_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CNT_W     = 32,
  localparam int SUM_W    = CNT_W + 2,
  localparam int CHIP_W   = SUM_W + 10,
  localparam int CORE_W   = SUM_W + 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mbw_strb_t                   strb,
  input  logic                        rdDispEvt,
  input  logic                        wrDispEvt,
  input  logic                        pfDispEvt,
  input  logic [NUM_CORES-1:0]        coreDemandMissEvt,
  input  logic [NUM_CORES-1:0]        coreOuterMissEvt,
  input  logic [NUM_CORES-1:0]        coreOuterLdMissEvt,
  input  logic [NUM_CORES-1:0]        coreCastoutEvt,
  input  logic [NUM_CORES-1:0]        corePfMissEvt,
  output logic [CHIP_W-1:0]           chipBytes,
  output logic [NUM_CORES*CORE_W-1:0] coreBytes,
  output logic [CNT_W-1:0]            rdAccMon
);
  // ---------------- chip level ----------------
  logic [CNT_W-1:0] rdCnt, wrCnt, pfCnt;
  logic [CNT_W-1:0] rdNxt, wrNxt, pfNxt;
  logic [CNT_W-1:0] chipRdNet;
  logic [SUM_W-1:0] chipSum;

  mbw_sat_acc #(.W(CNT_W)) rdAcc_i (.clk(clk), .rstN(rstN), .clear(strb.clearAcc),
    .inc(rdDispEvt), .cnt(rdCnt), .nxt(rdNxt));
  mbw_sat_acc #(.W(CNT_W)) wrAcc_i (.clk(clk), .rstN(rstN), .clear(strb.clearAcc),
    .inc(wrDispEvt), .cnt(wrCnt), .nxt(wrNxt));
  mbw_sat_acc #(.W(CNT_W)) pfAcc_i (.clk(clk), .rstN(rstN), .clear(strb.clearAcc),
    .inc(pfDispEvt), .cnt(pfCnt), .nxt(pfNxt));

  assign rdAccMon  = rdCnt;
  // prefetch dispatches are also counted as reads: remove them, floor at zero
  assign chipRdNet = (rdNxt >= pfNxt) ? (rdNxt - pfNxt) : '0;
  assign chipSum   = SUM_W'(chipRdNet) + SUM_W'(wrNxt) + SUM_W'(pfNxt);

  always_ff @(posedge clk) begin
    if (!rstN)               chipBytes <= '0;
    else if (strb.sampleEnd) chipBytes <= {chipSum, 10'b0};
  end

  // ---------------- per core ----------------
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [CNT_W-1:0] dmCnt, omCnt, olCnt, coCnt, pmCnt;
    logic [CNT_W-1:0] dmNxt, omNxt, olNxt, coNxt, pmNxt;
    logic [CNT_W-1:0] omNet;
    logic [SUM_W-1:0] coreSum;

    mbw_sat_acc #(.W(CNT_W)) dmAcc_i (.clk(clk), .rstN(rstN), .clear(strb.clearAcc),
      .inc(coreDemandMissEvt[c]), .cnt(dmCnt), .nxt(dmNxt));
    mbw_sat_acc #(.W(CNT_W)) omAcc_i (.clk(clk), .rstN(rstN), .clear(strb.clearAcc),
      .inc(coreOuterMissEvt[c]), .cnt(omCnt), .nxt(omNxt));
    mbw_sat_acc #(.W(CNT_W)) olAcc_i (.clk(clk), .rstN(rstN), .clear(strb.clearAcc),
      .inc(coreOuterLdMissEvt[c]), .cnt(olCnt), .nxt(olNxt));
    mbw_sat_acc #(.W(CNT_W)) coAcc_i (.clk(clk), .rstN(rstN), .clear(strb.clearAcc),
      .inc(coreCastoutEvt[c]), .cnt(coCnt), .nxt(coNxt));
    mbw_sat_acc #(.W(CNT_W)) pmAcc_i (.clk(clk), .rstN(rstN), .clear(strb.clearAcc),
      .inc(corePfMissEvt[c]), .cnt(pmCnt), .nxt(pmNxt));

    // misses other than demand loads, floored at zero, halved on the total
    assign omNet   = (omNxt >= olNxt) ? (omNxt - olNxt) : '0;
    assign coreSum = SUM_W'(dmNxt) + SUM_W'(omNet >> 1)
                   + SUM_W'(coNxt >> 1) + SUM_W'(pmNxt >> 1);

    always_ff @(posedge clk) begin
      if (!rstN)
        coreBytes[c*CORE_W +: CORE_W] <= '0;
      else if (strb.sampleEnd)
        coreBytes[c*CORE_W +: CORE_W] <= {coreSum, 7'b0};
    end
  end
endmodule

// File: rtl/mem_bw_acct.sv
module mem_bw_acct
  import mbw_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CNT_W     = 32,
  parameter int LEN_W     = 16,
  localparam int CHIP_W   = CNT_W + 12,
  localparam int CORE_W   = CNT_W + 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LEN_W-1:0]            intervalLen,
  input  logic                        rdDispEvt,
  input  logic                        wrDispEvt,
  input  logic                        pfDispEvt,
  input  logic [NUM_CORES-1:0]        coreDemandMissEvt,
  input  logic [NUM_CORES-1:0]        coreOuterMissEvt,
  input  logic [NUM_CORES-1:0]        coreOuterLdMissEvt,
  input  logic [NUM_CORES-1:0]        coreCastoutEvt,
  input  logic [NUM_CORES-1:0]        corePfMissEvt,
  output logic [CHIP_W-1:0]           chipBytes,
  output logic [NUM_CORES*CORE_W-1:0] coreBytes,
  output logic                        done
);
  mbw_strb_t        strb;
  logic [CNT_W-1:0] rdAccMon;

  mbw_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .intervalLen(intervalLen), .strb(strb), .done(done));

  mbw_datapath #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdDispEvt(rdDispEvt), .wrDispEvt(wrDispEvt), .pfDispEvt(pfDispEvt),
    .coreDemandMissEvt(coreDemandMissEvt), .coreOuterMissEvt(coreOuterMissEvt),
    .coreOuterLdMissEvt(coreOuterLdMissEvt), .coreCastoutEvt(coreCastoutEvt),
    .corePfMissEvt(corePfMissEvt),
    .chipBytes(chipBytes), .coreBytes(coreBytes), .rdAccMon(rdAccMon));
endmodule

// File: rtl/mbw_checker.sv
module mbw_checker #(
  parameter int NUM_CORES = 2,
  parameter int CNT_W     = 32,
  localparam int CHIP_W   = CNT_W + 12,
  localparam int CORE_W   = CNT_W + 9
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        sampleEnd,
  input logic                        done,
  input logic [CHIP_W-1:0]           chipBytes,
  input logic [NUM_CORES*CORE_W-1:0] coreBytes,
  input logic [CNT_W-1:0]            rdAcc
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  p_done_after_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleEnd |=> done);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEnd |=> !done);

  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEnd |=> ($stable(chipBytes) && $stable(coreBytes)));

  p_clear_at_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleEnd |=> (rdAcc == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleEnd && rdAcc == MAXV) |=> (rdAcc == MAXV));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEnd |=> (rdAcc >= $past(rdAcc)));
endmodule

bind mem_bw_acct mbw_checker #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .sampleEnd(strb.sampleEnd), .done(done),
  .chipBytes(chipBytes), .coreBytes(coreBytes), .rdAcc(rdAccMon));

// File: tb/mem_bw_acct_tb_top.sv
module mem_bw_acct_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC     = 2;
  localparam int CW     = 6;
  localparam int LW     = 8;
  localparam int CHIP_W = CW + 12;
  localparam int CORE_W = CW + 9;
  localparam int NVEC   = 5;

  // rd, wr, pf, demandMiss, outerMiss, outerLdMiss, castout, pfMiss (core 0)
  // core 1 uses the same counts with outerMiss and outerLdMiss exchanged
  localparam int VEC [NVEC][8] = '{
    '{10, 3,  4,  2,  9,  4,  5,  7},
    '{ 3, 0,  8,  0,  0,  0,  0,  0},
    '{16, 16, 16, 16, 16, 16, 16, 16},
    '{ 0, 0,  0,  0,  1,  0,  1,  1},
    '{ 7, 5,  0,  5, 15,  2,  3, 11}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [LW-1:0] intervalLen;
  logic rdDispEvt, wrDispEvt, pfDispEvt;
  logic [NC-1:0] coreDemandMissEvt, coreOuterMissEvt, coreOuterLdMissEvt;
  logic [NC-1:0] coreCastoutEvt, corePfMissEvt;
  logic [CHIP_W-1:0]    chipBytes;
  logic [NC*CORE_W-1:0] coreBytes;
  logic done;

  int nChecks = 0;
  int nFails  = 0;
  int cur [8];
  longint prevChip = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bw_acct #(.NUM_CORES(NC), .CNT_W(CW), .LEN_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .intervalLen(intervalLen),
    .rdDispEvt(rdDispEvt), .wrDispEvt(wrDispEvt), .pfDispEvt(pfDispEvt),
    .coreDemandMissEvt(coreDemandMissEvt), .coreOuterMissEvt(coreOuterMissEvt),
    .coreOuterLdMissEvt(coreOuterLdMissEvt), .coreCastoutEvt(coreCastoutEvt),
    .corePfMissEvt(corePfMissEvt), .chipBytes(chipBytes), .coreBytes(coreBytes),
    .done(done));

  function automatic longint sat(input int n);
    return (n > 63) ? 63 : n;
  endfunction

  function automatic longint expChip(input int rd, input int wr, input int pf);
    longint r = sat(rd), w = sat(wr), p = sat(pf);
    longint net = (r >= p) ? r - p : 0;
    return (net + w + p) * 1024;
  endfunction

  function automatic longint expCore(input int dm, input int om, input int ol,
                                     input int co, input int pm);
    longint m = sat(om), l = sat(ol);
    longint net = (m >= l) ? m - l : 0;
    return (sat(dm) + net / 2 + sat(co) / 2 + sat(pm) / 2) * 128;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one window of L cycles starting at the current falling edge.
  // Event type k pulses in cycles c < cur[k].
  task automatic runInterval(input int L, input string req);
    for (int c = 0; c < L; c++) begin
      if (c == 1) begin
        check("R2 done low inside window", done, 0);
        check("R6 chip total held", chipBytes, prevChip);
      end
      rdDispEvt = (c < cur[0]);
      wrDispEvt = (c < cur[1]);
      pfDispEvt = (c < cur[2]);
      coreDemandMissEvt  = {NC{c < cur[3]}};
      coreOuterMissEvt   = {c < cur[5], c < cur[4]};
      coreOuterLdMissEvt = {c < cur[4], c < cur[5]};
      coreCastoutEvt     = {NC{c < cur[6]}};
      corePfMissEvt      = {NC{c < cur[7]}};
      @(negedge clk);
    end
    check({"R2 done at window end ", req}, done, 1);
    check({"R4 chip bytes ", req}, chipBytes, expChip(cur[0], cur[1], cur[2]));
    check({"R5 core0 bytes ", req}, coreBytes[0 +: CORE_W],
          expCore(cur[3], cur[4], cur[5], cur[6], cur[7]));
    check({"R7 core1 bytes ", req}, coreBytes[CORE_W +: CORE_W],
          expCore(cur[3], cur[5], cur[4], cur[6], cur[7]));
    prevChip = expChip(cur[0], cur[1], cur[2]);
  endtask

  initial begin
    rstN = 1'b0;
    intervalLen = 8'd16;
    rdDispEvt = 0; wrDispEvt = 0; pfDispEvt = 0;
    coreDemandMissEvt = '0; coreOuterMissEvt = '0; coreOuterLdMissEvt = '0;
    coreCastoutEvt = '0; corePfMissEvt = '0;
    repeat (3) @(negedge clk);
    check("R1 reset chip", chipBytes, 0);
    check("R1 reset core", coreBytes, 0);
    check("R1 reset done", done, 0);
    rstN = 1'b1;

    // vector table: includes last-cycle events (R2), clamps (R7), halving on totals (R5)
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < 8; k++) cur[k] = VEC[v][k];
      runInterval(16, $sformatf("vec%0d", v));
    end

    // R3: saturation over a long window (counters max out at 63)
    intervalLen = 8'd80;
    cur = '{80, 80, 0, 0, 0, 0, 80, 0};
    runInterval(80, "R3 saturated");

    // R6: quiet window after saturation must report zero
    intervalLen = 8'd16;
    cur = '{0, 0, 0, 0, 0, 0, 0, 0};
    runInterval(16, "R6 cleared");

    rdDispEvt = 0; wrDispEvt = 0; pfDispEvt = 0;
    coreDemandMissEvt = '0; coreOuterMissEvt = '0; coreOuterLdMissEvt = '0;
    coreCastoutEvt = '0; corePfMissEvt = '0;
    @(negedge clk);
    check("R2 done single cycle", done, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule